// File: doc/BRIEF.md
# UART Sleep Entry and Wake Controller

This block decides when an idle UART channel may drop into a low-power sleep state and when it has to come back out. It watches a sleep request, an idle indication from the channel (FIFOs empty, no line activity) and the receive-data pin. A single mode select changes two things at once: the pin condition that can hold off sleep entry, and the pin event that ends sleep.

In level mode a low receive line keeps the channel awake, and a sleeping channel wakes as soon as the line is low. In edge mode the channel may sleep with the line at either level. It then wakes when the line moves away from the value it had at sleep entry, in either direction.

The receive pin is asynchronous, so it passes through a small synchronizer first. The outputs are a registered sleep flag and a one-clock wake pulse. These feed the clock-gating and interrupt logic of the channel, which is outside this block.

Top module: `uart_slp_ctrl`

## Requirements
- R1: `sleep_o` rises only in the cycle after a clock edge at which `sleep_req_i` and `chan_idle_i` were both 1, the block was armed and the mode's pin condition allowed entry.
- R2: With `edge_mode_i` = 0 (level mode), sleep is not entered while the synchronized receive line is 0.
- R3: With `edge_mode_i` = 0, a sleeping channel wakes at the edge after the synchronized receive line reads 0.
- R4: With `edge_mode_i` = 1 (edge mode), sleep is entered even while the synchronized receive line is 0.
- R5: With `edge_mode_i` = 1, a sleeping channel wakes when the synchronized receive line differs from its value at sleep entry, rising or falling. While it keeps that value, the channel stays asleep.
- R6: Driving `sleep_req_i` to 0 while asleep wakes the channel at the next clock edge, in either mode.
- R7: On every wake, `sleep_o` falls and `wake_o` is 1 for exactly one cycle. `wake_o` is never 1 at any other time.
- R8: After a wake, sleep is not re-entered until `chan_idle_i` has been 0 for at least one clock edge and then returns to 1.
- R9: `rx_pin_i` passes through two flops. A change on the pin reaches the wake decision after two edges, so a pin-driven wake shows at the outputs after the third edge.
- R10: During and right after reset, `sleep_o` and `wake_o` are 0, the synchronized receive line reads 1 and the block is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Sleep permitted by configuration |
| chan_idle_i | input | 1 | Channel has no pending work |
| edge_mode_i | input | 1 | 0 = level-sensitive, 1 = edge-sensitive |
| rx_pin_i | input | 1 | Raw receive-data pin, asynchronous |
| sleep_o | output | 1 | Channel is in sleep state |
| wake_o | output | 1 | One-cycle pulse on each wake |

## Verification
The assertions are checked on every cycle. They cover the pairing of every falling sleep flag with a single wake pulse, entry only after a request while idle, the level-mode entry block and wake on a low line, and the immediate wake when the request drops. Other properties span several events, and only the bench's scenarios show them. These are the three-edge latency from pin to wake, edge-mode wake in both directions against the value captured at entry, sleeping through a held low line in edge mode, and the re-arm rule that needs the idle indication to drop before sleep is entered again.

// File: rtl/uart_slp_pkg.sv
package uart_slp_pkg;

    typedef enum logic {
        MODE_LEVEL = 1'b0,
        MODE_EDGE  = 1'b1
    } slp_mode_e;

    typedef struct packed {
        logic asleep;
        logic wake;
        logic armed;
        logic snap;
    } slp_state_t;

    localparam slp_state_t SLP_RESET = '{asleep: 1'b0, wake: 1'b0, armed: 1'b1, snap: 1'b1};

endpackage

// File: rtl/uart_slp_sync.sv
module uart_slp_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[LAST-1:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[LAST];
endmodule

// File: rtl/uart_slp_cond.sv
module uart_slp_cond
    import uart_slp_pkg::*;
(
    input  logic      asleep_i,
    input  logic      req_i,
    input  logic      idle_i,
    input  logic      armed_i,
    input  slp_mode_e mode_i,
    input  logic      rx_s_i,
    input  logic      snap_i,
    output logic      enter_o,
    output logic      wake_o
);
    logic pin_allows;
    logic pin_wakes;

    always_comb begin
        unique case (mode_i)
            MODE_LEVEL: begin
                pin_allows = rx_s_i;
                pin_wakes  = !rx_s_i;
            end
            default: begin
                pin_allows = 1'b1;
                pin_wakes  = rx_s_i ^ snap_i;
            end
        endcase
        enter_o = !asleep_i && req_i && idle_i && armed_i && pin_allows;
        wake_o  = asleep_i && (!req_i || pin_wakes);
    end
endmodule

// File: rtl/uart_slp_ctrl.sv
module uart_slp_ctrl
    import uart_slp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sleep_req_i,
    input  logic chan_idle_i,
    input  logic edge_mode_i,
    input  logic rx_pin_i,
    output logic sleep_o,
    output logic wake_o
);
    slp_state_t st_d, st_q;
    logic       rx_s;
    logic       enter;
    logic       wake_now;
    slp_mode_e  mode;

    assign mode = slp_mode_e'(edge_mode_i);

    uart_slp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (rx_pin_i),
        .q_o   (rx_s)
    );

    uart_slp_cond u_cond (
        .asleep_i(st_q.asleep),
        .req_i   (sleep_req_i),
        .idle_i  (chan_idle_i),
        .armed_i (st_q.armed),
        .mode_i  (mode),
        .rx_s_i  (rx_s),
        .snap_i  (st_q.snap),
        .enter_o (enter),
        .wake_o  (wake_now)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wake = wake_now;
        if (enter) begin
            st_d.asleep = 1'b1;
            st_d.snap   = rx_s;
        end else if (wake_now) begin
            st_d.asleep = 1'b0;
        end
        if (wake_now)          st_d.armed = 1'b0;
        else if (!chan_idle_i) st_d.armed = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= SLP_RESET;
        else         st_q <= st_d;
    end

    assign sleep_o = st_q.asleep;
    assign wake_o  = st_q.wake;
endmodule

// File: rtl/uart_slp_ctrl_chk.sv
module uart_slp_ctrl_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic sleep_req_i,
    input logic chan_idle_i,
    input logic edge_mode_i,
    input logic rx_s,
    input logic sleep_o,
    input logic wake_o
);
    p_wake_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> $fell(sleep_o));
    p_fall_pulses_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sleep_o) |-> wake_o);
    p_wake_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |=> !wake_o);
    p_entry_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sleep_o) |-> $past(sleep_req_i && chan_idle_i));
    p_level_block_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sleep_o && !edge_mode_i && !rx_s) |=> !sleep_o);
    p_level_wake_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sleep_o && !edge_mode_i && !rx_s) |=> (!sleep_o && wake_o));
    p_req_wake_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sleep_o && !sleep_req_i) |=> (!sleep_o && wake_o));
endmodule

bind uart_slp_ctrl uart_slp_ctrl_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_req_i(sleep_req_i),
    .chan_idle_i(chan_idle_i),
    .edge_mode_i(edge_mode_i),
    .rx_s       (rx_s),
    .sleep_o    (sleep_o),
    .wake_o     (wake_o)
);

// File: tb/uart_slp_ctrl_test.sv
module uart_slp_ctrl_test;
    localparam time TCK = 8ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req = 1'b0, idle = 1'b1, emode = 1'b0, rx = 1'b1;
    logic sleep_w, wake_w;
    int   checks = 0, errors = 0;

    // reference state
    logic m_s1, m_s2, m_sleep, m_wake, m_arm, m_snap;

    always #(TCK/2) clk = ~clk;

    uart_slp_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(req), .chan_idle_i(idle),
        .edge_mode_i(emode), .rx_pin_i(rx), .sleep_o(sleep_w), .wake_o(wake_w)
    );

    function automatic logic f_enter(logic sl, logic rq, logic id, logic ar, logic em, logic s2);
        return !sl && rq && id && ar && (em || s2);
    endfunction

    function automatic logic f_wake(logic sl, logic rq, logic em, logic s2, logic sn);
        return sl && (!rq || (em ? (s2 != sn) : !s2));
    endfunction

    task automatic chk(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_s1 = 1'b1; m_s2 = 1'b1; m_sleep = 1'b0; m_wake = 1'b0; m_arm = 1'b1; m_snap = 1'b1;
    endtask

    task automatic tick(string tag);
        logic en, wk;
        @(posedge clk);
        en = f_enter(m_sleep, req, idle, m_arm, emode, m_s2);
        wk = f_wake(m_sleep, req, emode, m_s2, m_snap);
        if (en) m_snap = m_s2;
        m_sleep = m_sleep ? !wk : en;
        m_wake  = wk;
        m_arm   = wk ? 1'b0 : (!idle ? 1'b1 : m_arm);
        m_s2 = m_s1; m_s1 = rx;
        @(negedge clk);
        chk(tag, sleep_w, m_sleep, "model sleep");
        chk(tag, wake_w, m_wake, "model wake");
    endtask

    task automatic ticks(string tag, int n);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    initial begin
        #(TCK * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (4) @(negedge clk);
        chk("R10", sleep_w, 1'b0, "sleep in reset");
        chk("R10", wake_w, 1'b0, "wake in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", sleep_w, 1'b0, "sleep after reset");

        // R1: idle gate
        req = 1; idle = 0; tick("R1");
        chk("R1", sleep_w, 1'b0, "no entry while busy");
        idle = 1; tick("R1");
        chk("R1", sleep_w, 1'b1, "entry when idle");

        // R3/R9: level wake latency
        rx = 0; ticks("R9", 2);
        chk("R9", sleep_w, 1'b1, "still asleep two edges after pin");
        tick("R3");
        chk("R3", sleep_w, 1'b0, "level wake");
        chk("R7", wake_w, 1'b1, "wake pulse");
        tick("R7");
        chk("R7", wake_w, 1'b0, "pulse one cycle");

        // R2: level mode blocked by low line
        idle = 0; tick("R2"); idle = 1; ticks("R2", 3);
        chk("R2", sleep_w, 1'b0, "level blocked by low rx");

        // R4: edge mode enters with low line
        emode = 1; tick("R4");
        chk("R4", sleep_w, 1'b1, "edge entry with low rx");
        ticks("R5", 4);
        chk("R5", sleep_w, 1'b1, "held level keeps sleep");
        rx = 1; ticks("R5", 3);
        chk("R5", sleep_w, 1'b0, "rising edge wake");
        chk("R5", wake_w, 1'b1, "rising edge pulse");

        // R8: re-arm rule
        ticks("R8", 3);
        chk("R8", sleep_w, 1'b0, "no reentry before idle drop");
        idle = 0; tick("R8"); idle = 1; tick("R8");
        chk("R8", sleep_w, 1'b1, "reentry after idle drop");
        rx = 0; ticks("R5", 3);
        chk("R5", sleep_w, 1'b0, "falling edge wake");
        chk("R5", wake_w, 1'b1, "falling edge pulse");

        // R6: request removal
        idle = 0; tick("R6"); idle = 1; tick("R6");
        chk("R6", sleep_w, 1'b1, "asleep before req drop");
        req = 0; tick("R6");
        chk("R6", sleep_w, 0, "req drop wakes");
        chk("R6", wake_w, 1, "req drop pulse");

        // random phase, reference comparison on every cycle
        for (int i = 0; i < 4000; i++) begin
            req   = ($urandom % 8) != 0;
            idle  = ($urandom % 4) != 0;
            rx    = ($urandom % 5) == 0 ? ~rx : rx;
            emode = ($urandom % 40) == 0 ? ~emode : emode;
            tick("R1");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule